// File: doc/BRIEF.md
# Board interrupt aggregator register bank

This block sits on a board-control bus and combines two jobs. It keeps a set of plain 32-bit storage registers: two for LED data, one for LED control, one for switches, three miscellaneous write values, one miscellaneous read value and two card-slot values. It also folds sixteen external interrupt lines into a single interrupt request for a parent interrupt controller. Software reaches both through a synchronous register bus made of address, write enable, write data and read data. The address is decoded over a 1 MiB window.

The interrupt side has two registers: an enable mask and a capture register that software can also write. Every clock, each input line is compared with its level from the previous cycle. If a line has changed and its enable bit is set, the capture register is overwritten with a one-hot code for that line, and the outgoing request takes the line's new level. If several enabled lines change in the same cycle, the lowest-numbered one is taken. The level of a disabled line is still tracked, so enabling it later does not report a change that is already old.

Top module: `board_irq_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register, the tracked line levels, the read data and the interrupt output.
- R2: The ten storage registers sit at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. Each keeps the full 32-bit value written and returns it on read.
- R3: Writes to the enable mask (offset 0xC0) and to the capture register (offset 0xD0) are ANDed with 0x000FEEFF, so bits 8, 12 and 20 to 31 always read back 0.
- R4: Read data appears in the cycle after the address is presented. A write takes effect at the clock edge where write enable is high, so a read of the same offset in that cycle returns the old value.
- R5: When input line n has a level different from its previous sampled level and enable bit n is 1, then after that clock edge the capture register holds only bit n and the interrupt output equals the line's new level.
- R6: A change on a line whose enable bit is 0 leaves the capture register and the interrupt output unchanged. The line's level is still tracked, so setting its enable bit afterwards raises no event until the line changes again.
- R7: When several enabled lines change in the same cycle, the lowest-numbered one sets the capture register and the output level.
- R8: Offsets that are not defined (the address compares on all 20 bits, so an alias such as 0x10010 also counts) read 0, and writes to them change no register.
- R9: Because enable bits 8 and 12 cannot be set, changes on lines 8 and 12 never update the capture register or the output.
- R10: If an enabled line change is captured in the same cycle as a bus write to the capture register, the capture wins.
- R11: A bus write to the capture register never changes the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte offset within the window |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External interrupt lines |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
Single enabled lines are raised and then lowered. This shows that the one-hot capture and the output level follow rises and falls alike. Lines are also toggled while disabled and then enabled, which tells a design that tracks levels apart from one that latches stale edges. Lines 8 and 12 are toggled, which exposes a mask that lets the two reserved bits through. Two pairs of lines change together to settle the priority order, and a line change that lands in the same cycle as a bus write to the capture register shows which of the two wins.

// File: rtl/birq_pkg.sv
package birq_pkg;

  localparam int NUM_STORE = 10;

  localparam logic [7:0] ENA_OFFSET = 8'hC0;
  localparam logic [7:0] SCL_OFFSET = 8'hD0;

  // writable bits of the enable and capture registers
  localparam logic [31:0] IRQ_KEEP = 32'h000F_EEFF;

  // byte offset of each plain storage register
  function automatic logic [7:0] store_offset(input int idx);
    case (idx)
      0:       store_offset = 8'h10;
      1:       store_offset = 8'h14;
      2:       store_offset = 8'h40;
      3:       store_offset = 8'h60;
      4:       store_offset = 8'h80;
      5:       store_offset = 8'h84;
      6:       store_offset = 8'h88;
      7:       store_offset = 8'h90;
      8:       store_offset = 8'hE0;
      default: store_offset = 8'hE4;
    endcase
  endfunction

endpackage

// File: rtl/birq_decode.sv
module birq_decode
  import birq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NSTORE = NUM_STORE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSTORE-1:0] store_hit,
  output logic              ena_hit,
  output logic              scl_hit,
  output logic              any_hit
);

  for (genvar g = 0; g < NSTORE; g++) begin : g_hit
    assign store_hit[g] = (addr == ADDR_W'(store_offset(g)));
  end

  assign ena_hit = (addr == ADDR_W'(ENA_OFFSET));
  assign scl_hit = (addr == ADDR_W'(SCL_OFFSET));
  assign any_hit = (|store_hit) | ena_hit | scl_hit;

endmodule

// File: rtl/birq_store.sv
module birq_store #(
  parameter int DATA_W = 32,
  parameter int NSTORE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NSTORE-1:0] hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] st_q [NSTORE]
);

  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= '0;
      end else if (we && hit[g]) begin
        st_q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/birq_irq_agg.sv
module birq_irq_agg #(
  parameter int              NUM_IRQ = 16,
  parameter int              DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEEP  = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ena_we,
  input  logic               scl_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  ena_q,
  output logic [DATA_W-1:0]  scl_q,
  output logic               irq_out
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] lvl_q;
  logic [NUM_IRQ-1:0] live;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;

  // changed lines that are enabled; the old enable mask applies
  assign live     = (irq_in ^ lvl_q) & ena_q[NUM_IRQ-1:0];
  assign pick_any = |live;

  // lowest-numbered changed line wins
  always_comb begin
    pick_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (live[i]) pick_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      ena_q   <= '0;
      scl_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      lvl_q <= irq_in;
      if (ena_we) ena_q <= wdata & KEEP;
      if (pick_any) begin
        scl_q   <= DATA_W'(1) << pick_idx;
        irq_out <= irq_in[pick_idx];
      end else if (scl_we) begin
        scl_q <= wdata & KEEP;
      end
    end
  end

endmodule

// File: rtl/birq_rdmux.sv
module birq_rdmux #(
  parameter int DATA_W = 32,
  parameter int NSTORE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTORE-1:0] store_hit,
  input  logic              ena_hit,
  input  logic              scl_hit,
  input  logic [DATA_W-1:0] st_q [NSTORE],
  input  logic [DATA_W-1:0] ena_q,
  input  logic [DATA_W-1:0] scl_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NSTORE; i++) begin
      if (store_hit[i]) rd_next = rd_next | st_q[i];
    end
    if (ena_hit) rd_next = rd_next | ena_q;
    if (scl_hit) rd_next = rd_next | scl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/board_irq_regbank.sv
module board_irq_regbank
  import birq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               irq_out
);

  localparam int              NSTORE = NUM_STORE;
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(IRQ_KEEP);

  logic [NSTORE-1:0] store_hit;
  logic              ena_hit;
  logic              scl_hit;
  logic              any_hit;
  logic [DATA_W-1:0] st_q [NSTORE];
  logic [DATA_W-1:0] ena_w;
  logic [DATA_W-1:0] scl_w;

  birq_decode #(
    .ADDR_W (ADDR_W),
    .NSTORE (NSTORE)
  ) u_dec (
    .addr      (bus_addr),
    .store_hit (store_hit),
    .ena_hit   (ena_hit),
    .scl_hit   (scl_hit),
    .any_hit   (any_hit)
  );

  birq_store #(
    .DATA_W (DATA_W),
    .NSTORE (NSTORE)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .hit   (store_hit),
    .wdata (bus_wdata),
    .st_q  (st_q)
  );

  birq_irq_agg #(
    .NUM_IRQ (NUM_IRQ),
    .DATA_W  (DATA_W),
    .KEEP    (KEEP)
  ) u_agg (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .ena_we  (bus_we & ena_hit),
    .scl_we  (bus_we & scl_hit),
    .wdata   (bus_wdata),
    .ena_q   (ena_w),
    .scl_q   (scl_w),
    .irq_out (irq_out)
  );

  birq_rdmux #(
    .DATA_W (DATA_W),
    .NSTORE (NSTORE)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .store_hit (store_hit),
    .ena_hit   (ena_hit),
    .scl_hit   (scl_hit),
    .st_q      (st_q),
    .ena_q     (ena_w),
    .scl_q     (scl_w),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/birq_chk.sv
module birq_chk #(
  parameter int                DATA_W  = 32,
  parameter int                NUM_IRQ = 16,
  parameter logic [DATA_W-1:0] KEEP    = '1
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic               irq_out,
  input logic [NUM_IRQ-1:0] ena,
  input logic [DATA_W-1:0]  scl,
  input logic               any_hit,
  input logic               cfg_hit
);

  // R1: reset leaves output and read data low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq_out == 1'b0 && rdata == '0));

  // R3: reserved bits of the interrupt registers read as zero
  assert_keep_mask_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_hit |=> ((rdata & ~KEEP) == '0));

  // R5: an enabled change leaves exactly one capture bit set
  assert_onehot_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (((irq_in ^ $past(irq_in)) & ena) != '0)) |=> ($countones(scl) == 1));

  // R6 / R11: no enabled change, output holds
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (((irq_in ^ $past(irq_in)) & ena) == '0)) |=> $stable(irq_out));

  // R8: undefined offsets read zero
  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> (rdata == '0));

endmodule

bind board_irq_regbank birq_chk #(
  .DATA_W  (DATA_W),
  .NUM_IRQ (NUM_IRQ),
  .KEEP    (KEEP)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rdata   (bus_rdata),
  .irq_in  (irq_in),
  .irq_out (irq_out),
  .ena     (ena_w[NUM_IRQ-1:0]),
  .scl     (scl_w),
  .any_hit (any_hit),
  .cfg_hit (ena_hit | scl_hit)
);

// File: tb/board_irq_regbank_test.sv
module board_irq_regbank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  board_irq_regbank uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_st [10];
  logic [31:0] m_en, m_scl, m_rd;
  logic [15:0] m_lvl;
  logic        m_out;
  string       m_tag = "R1";
  bit          m_ready = 0;

  function automatic int st_index(input logic [19:0] a);
    case (a)
      20'h10: return 0;  20'h14: return 1;  20'h40: return 2;
      20'h60: return 3;  20'h80: return 4;  20'h84: return 5;
      20'h88: return 6;  20'h90: return 7;  20'hE0: return 8;
      20'hE4: return 9;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 10; k++) m_st[k] = 0;
      m_en = 0; m_scl = 0; m_rd = 0; m_lvl = 0; m_out = 0; m_tag = "R1";
    end else begin
      int ix;
      logic [15:0] live;
      bit took;
      ix = st_index(bus_addr);
      if (ix >= 0) begin m_rd = m_st[ix]; m_tag = "R2"; end
      else if (bus_addr == 20'hC0) begin m_rd = m_en; m_tag = "R3"; end
      else if (bus_addr == 20'hD0) begin m_rd = m_scl; m_tag = "R5"; end
      else begin m_rd = 0; m_tag = "R8"; end
      live = (irq_in ^ m_lvl) & m_en[15:0];
      if (bus_we) begin
        if (ix >= 0) m_st[ix] = bus_wdata;
        else if (bus_addr == 20'hC0) m_en = bus_wdata & 32'h000FEEFF;
        else if (bus_addr == 20'hD0) m_scl = bus_wdata & 32'h000FEEFF;
      end
      took = 0;
      for (int b = 0; b < 16; b++) begin
        if (live[b] && !took) begin
          m_scl = 32'd1 << b;
          m_out = irq_in[b];
          took = 1;
        end
      end
      m_lvl = irq_in;
    end
    m_ready = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_ready && !done) begin
      chk(m_tag, bus_rdata, m_rd);
      chk("R5", {31'd0, irq_out}, {31'd0, m_out});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic lines(input logic [15:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  logic [19:0] offs [10] = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80,
                             20'h84, 20'h88, 20'h90, 20'hE0, 20'hE4};

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: everything reads zero after reset
    for (int i = 0; i < 10; i++) begin rd(offs[i], v); chk("R1", v, 32'h0); end
    rd(20'hC0, v); chk("R1", v, 32'h0);
    rd(20'hD0, v); chk("R1", v, 32'h0);
    chk("R1", {31'd0, irq_out}, 32'h0);

    // R2: full-width storage
    for (int i = 0; i < 10; i++) wr(offs[i], 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
    for (int i = 0; i < 10; i++) begin
      rd(offs[i], v); chk("R2", v, 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
    end

    // R3: masked interrupt registers; R11: capture write leaves output
    wr(20'hC0, 32'hFFFF_FFFF); rd(20'hC0, v); chk("R3", v, 32'h000F_EEFF);
    wr(20'hD0, 32'hFFFF_FFFF); rd(20'hD0, v); chk("R3", v, 32'h000F_EEFF);
    chk("R11", {31'd0, irq_out}, 32'h0);
    wr(20'hD0, 32'h0);

    // R4: read during write returns old value, then the new one
    bus_addr = 20'h10; bus_wdata = 32'h1234_5678; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    chk("R4", bus_rdata, 32'hA500_0000 ^ 32'h0101_0101);
    rd(20'h10, v); chk("R4", v, 32'h1234_5678);

    // R5: rise and fall of an enabled line
    lines(16'h0008); chk("R5", {31'd0, irq_out}, 32'h1);
    rd(20'hD0, v); chk("R5", v, 32'h8);
    lines(16'h0000); chk("R5", {31'd0, irq_out}, 32'h0);
    rd(20'hD0, v); chk("R5", v, 32'h8);

    // R9: lines 8 and 12 cannot be enabled
    lines(16'h0100); chk("R9", {31'd0, irq_out}, 32'h0);
    lines(16'h1100); rd(20'hD0, v); chk("R9", v, 32'h8);

    // R6: disabled change tracked, no late event when enabled
    wr(20'hC0, 32'h0);
    lines(16'h1104); chk("R6", {31'd0, irq_out}, 32'h0);
    rd(20'hD0, v); chk("R6", v, 32'h8);
    wr(20'hC0, 32'h0000_FFFF);
    rd(20'hD0, v); chk("R6", v, 32'h8);
    lines(16'h1100); rd(20'hD0, v); chk("R6", v, 32'h4);

    // R7: lowest-numbered simultaneous change wins
    lines(16'h1320); chk("R7", {31'd0, irq_out}, 32'h1);
    rd(20'hD0, v); chk("R7", v, 32'h20);
    lines(16'h5322); rd(20'hD0, v); chk("R7", v, 32'h2);

    // R10: capture beats a same-cycle bus write
    irq_in = 16'h5362;
    wr(20'hD0, 32'h0000_0003);
    rd(20'hD0, v); chk("R10", v, 32'h40);
    chk("R10", {31'd0, irq_out}, 32'h1);

    // R8: undefined offsets and aliases
    wr(20'h20, 32'hDEAD_BEEF); rd(20'h20, v); chk("R8", v, 32'h0);
    wr(20'h10010, 32'hCAFE_F00D); rd(20'h10010, v); chk("R8", v, 32'h0);
    rd(20'h10, v); chk("R8", v, 32'h1234_5678);
    rd(20'hFFFFF, v); chk("R8", v, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule